// File: doc/BRIEF.md
# Low-Power Multiplier Self-Test Pattern Generator

This block produces test vectors for an n×n multiplier that is embedded in a datapath. It also compacts the multiplier's products into a signature. An 8-bit sequence counter produces 256 codes per session. The three low code bits are fanned out in a repeating pattern across every position of operand A, and the five high code bits are fanned out the same way across operand B. Two static map parameters route each code bit to a group of operand positions. They are chosen so that the bits that toggle least feed the groups that carry the most switched capacitance. The counter can step in plain binary or in reflected Gray code. In Gray mode only one generator bit changes per vector, which lowers the switching at the multiplier inputs.

A small controller has three states: `ST_IDLE`, `ST_RUN` and `ST_DONE`. It has these transitions:

- `ST_IDLE`→`ST_RUN` on `start`.
- `ST_RUN`→`ST_DONE` when the counter reaches its last code.
- `ST_DONE`→`ST_RUN` on `start`.

`start` is ignored while in `ST_RUN`. The counting mode is latched when a session begins. While a session runs, a 2n-bit multiple-input signature register absorbs the product returned on `prod_in` once per cycle. In `ST_DONE` the signature and the operand buses are frozen, so they can be compared.

Top module: `lpb_tpg`

## Requirements
- R1: After reset, `op_a` and `op_b` are all zero, `done` is low and `signature` is zero.
- R2: A `start` that is high at a clock edge while the block is idle or done begins a session. In the cycle after that edge the vector for count 0 is applied. On each later edge the count advances by one, for 256 vectors in total (counts 0 to 255).
- R3: If `gray_mode` was 0 at the starting edge, the 8-bit code equals the count.
- R4: If `gray_mode` was 1 at the starting edge, the code equals count XOR (count >> 1). Consecutive codes then differ in exactly one bit, and all 256 codes of a session are distinct.
- R5: `op_a[j]` equals code bit `A_MAP[2k+1:2k]`, where k = j mod 3. By default, group 0 takes code bit 2, group 1 takes bit 1 and group 2 takes bit 0.
- R6: `op_b[j]` equals code bit 3 + `B_MAP[3k+2:3k]`, where k = j mod 5. By default, group k takes code bit 3+(4−k), so group 0 gets code bit 7.
- R7: `done` goes high at the edge that follows the 256th vector, and stays high until the next `start`. While `done` is high, `op_a`, `op_b` and `signature` hold their values, with the operands still showing the code for count 255.
- R8: A `start` pulse during a running session has no effect on the vector sequence or the signature.
- R9: The signature is cleared at the starting edge. On each edge during a session it becomes (sig << 1) XOR (sig[2n−1] ? POLY : 0) XOR `prod_in`. By default POLY = 16'h100B.
- R10: Changing `gray_mode` during a session or while done does not change the running sequence or the held outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test session |
| gray_mode | input | 1 | 1 selects Gray counting, latched at start |
| prod_in | input | 2N | Product returned by the multiplier under test |
| op_a | output | N | Generated operand A |
| op_b | output | N | Generated operand B |
| done | output | 1 | Session finished, outputs frozen |
| signature | output | 2N | Compacted product signature |

## Verification
Two pairs of events can coincide. A `start` can arrive in the same cycle as a counter increment during `ST_RUN`. A `start` can also arrive in `ST_DONE`, where it clears the signature in the same cycle that would otherwise hold it. The bench drives a start pulse partway through a Gray session and flips `gray_mode` at the same moment. The scoreboard then still expects the unbroken original sequence and the running signature value at every vector. Sessions are also restarted directly from `ST_DONE`. There the scoreboard expects vector 0 and a zero signature in the very next cycle, and it checks that the held operands and signature never moved while `done` was high.

// File: rtl/lpb_pkg.sv
package lpb_pkg;
    localparam int unsigned CODE_W = 8;
    localparam int unsigned A_GRPS = 3;
    localparam int unsigned B_GRPS = CODE_W - A_GRPS;
    localparam int unsigned A_SELW = 2;
    localparam int unsigned B_SELW = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } lpb_state_e;

    function automatic logic [CODE_W-1:0] bin_to_gray(input logic [CODE_W-1:0] b);
        return b ^ (b >> 1);
    endfunction
endpackage

// File: rtl/lpb_seq_ctr.sv
module lpb_seq_ctr
    import lpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              gray,
    output logic [CODE_W-1:0] code,
    output logic              last
);
    logic [CODE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = &cnt_q;
    assign code = gray ? bin_to_gray(cnt_q) : cnt_q;
endmodule

// File: rtl/lpb_operand_map.sv
module lpb_operand_map #(
    parameter int unsigned N    = 8,
    parameter int unsigned GRPS = 3,
    parameter int unsigned SELW = 2,
    parameter logic [GRPS*SELW-1:0] MAP = '0
) (
    input  logic [GRPS-1:0] field,
    output logic [N-1:0]    op
);
    for (genvar j = 0; j < N; j++) begin : g_pos
        localparam int unsigned GRP = j % GRPS;
        localparam int unsigned SEL = int'(MAP[GRP*SELW +: SELW]);
        assign op[j] = field[SEL];
    end
endmodule

// File: rtl/lpb_misr.sv
module lpb_misr #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] POLY = 16'h100B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] data,
    output logic [W-1:0] sig
);
    logic [W-1:0] fb;

    assign fb = sig[W-1] ? POLY : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sig <= '0;
        else if (clr)
            sig <= '0;
        else if (en)
            sig <= {sig[W-2:0], 1'b0} ^ fb ^ data;
    end
endmodule

// File: rtl/lpb_tpg.sv
module lpb_tpg
    import lpb_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter logic [A_GRPS*A_SELW-1:0] A_MAP = 6'b00_01_10,
    parameter logic [B_GRPS*B_SELW-1:0] B_MAP = 15'b000_001_010_011_100,
    parameter logic [2*N-1:0] POLY = 16'h100B
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           gray_mode,
    input  logic [2*N-1:0] prod_in,
    output logic [N-1:0]   op_a,
    output logic [N-1:0]   op_b,
    output logic           done,
    output logic [2*N-1:0] signature
);
    localparam int unsigned PW = 2 * N;

    lpb_state_e state_q, state_d;
    logic gray_q;
    logic ctr_clr, ctr_en, misr_en, last;
    logic [CODE_W-1:0] code_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gray_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctr_clr)
                gray_q <= gray_mode;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last)  state_d = ST_DONE;
            ST_DONE: if (start) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctr_clr = 1'b0;
        ctr_en  = 1'b0;
        misr_en = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: ctr_clr = start;
            ST_RUN: begin
                ctr_en  = !last;
                misr_en = 1'b1;
            end
            ST_DONE: begin
                ctr_clr = start;
                done    = 1'b1;
            end
            default: ;
        endcase
    end

    lpb_seq_ctr i_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ctr_clr),
        .en   (ctr_en),
        .gray (gray_q),
        .code (code_w),
        .last (last)
    );

    lpb_operand_map #(.N(N), .GRPS(A_GRPS), .SELW(A_SELW), .MAP(A_MAP)) i_map_a (
        .field(code_w[A_GRPS-1:0]),
        .op   (op_a)
    );

    lpb_operand_map #(.N(N), .GRPS(B_GRPS), .SELW(B_SELW), .MAP(B_MAP)) i_map_b (
        .field(code_w[CODE_W-1:A_GRPS]),
        .op   (op_b)
    );

    lpb_misr #(.W(PW), .POLY(POLY)) i_misr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ctr_clr),
        .en   (misr_en),
        .data (prod_in),
        .sig  (signature)
    );
endmodule

// File: rtl/lpb_chk.sv
module lpb_chk #(
    parameter int unsigned N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           done,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic [2*N-1:0] signature,
    input logic [7:0]     code,
    input logic           gray,
    input logic           clr
);
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R7

    AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(op_a) && $stable(op_b))); // R7

    AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(signature)); // R7

    AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && op_a == '0 && op_b == '0 && signature == '0)); // R2

    AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (gray && !clr && code != 8'h00 && $past(code) != code && !$past(clr))
        |-> ($countones(code ^ $past(code)) == 1)); // R4
endmodule

bind lpb_tpg lpb_chk #(.N(N)) i_lpb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .op_a     (op_a),
    .op_b     (op_b),
    .signature(signature),
    .code     (code_w),
    .gray     (gray_q),
    .clr      (ctr_clr)
);

// File: tb/test_lpb_tpg.sv
`timescale 1ns/1ps
module test_lpb_tpg;
    localparam int N = 8;
    localparam logic [5:0]  AMAP = 6'b00_01_10;
    localparam logic [14:0] BMAP = 15'b000_001_010_011_100;
    localparam logic [15:0] POLY = 16'h100B;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, gray_mode = 1'b0;
    logic [N-1:0] op_a, op_b;
    logic [2*N-1:0] prod, signature;
    logic done;

    int errors = 0, checks = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    bit mon_on = 0, sess_gray = 0, have_prev = 0;
    logic [7:0] prev_code;
    logic [15:0] sig_m;
    bit seen [256];

    always #2 clk = ~clk;
    assign prod = op_a * op_b;

    lpb_tpg i_lpb_tpg (
        .clk(clk), .rst_n(rst_n), .start(start), .gray_mode(gray_mode),
        .prod_in(prod), .op_a(op_a), .op_b(op_b), .done(done), .signature(signature)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] rep_a(input logic [7:0] c);
        logic [N-1:0] r;
        for (int j = 0; j < N; j++) r[j] = c[AMAP[(j % 3) * 2 +: 2]];
        return r;
    endfunction

    function automatic logic [N-1:0] rep_b(input logic [7:0] c);
        logic [N-1:0] r;
        for (int j = 0; j < N; j++) r[j] = c[3 + BMAP[(j % 5) * 3 +: 3]];
        return r;
    endfunction

    function automatic logic [7:0] recover(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [7:0] c;
        for (int k = 0; k < 3; k++) c[AMAP[k*2 +: 2]] = a[k];
        for (int k = 0; k < 5; k++) c[3 + BMAP[k*3 +: 3]] = b[k];
        return c;
    endfunction

    function automatic logic [15:0] misr_step(input logic [15:0] s, input logic [15:0] d);
        return {s[14:0], 1'b0} ^ (s[15] ? POLY : 16'h0) ^ d;
    endfunction

    // Monitor: pops one expected code per applied vector
    always @(negedge clk) begin
        if (mon_on && exp_q.size() > 0) begin
            logic [7:0] c, rec;
            c = exp_q.pop_front();
            rec = recover(op_a, op_b);
            chk(op_a == rep_a(c), "R5 op_a replication", op_a, rep_a(c));
            chk(op_b == rep_b(c), "R6 op_b replication", op_b, rep_b(c));
            if (sess_gray) chk(rec == c, "R4 gray code R8 R10", rec, c);
            else           chk(rec == c, "R3 binary code R8 R10", rec, c);
            chk(done == 1'b0, "R7 done early", done, 0);
            chk(signature == sig_m, "R9 running signature", signature, sig_m);
            if (sess_gray && have_prev)
                chk($countones(rec ^ prev_code) == 1, "R4 one bit step", rec ^ prev_code, 0);
            if (sess_gray) seen[rec] = 1;
            prev_code = rec;
            have_prev = 1;
            sig_m = misr_step(sig_m, 16'(rep_a(c)) * 16'(rep_b(c)));
            if (exp_q.size() == 0) mon_on = 0;
        end
    end

    task automatic run_session(input bit g, input bit disturb);
        logic [7:0] lastc;
        int uniq;
        for (int i = 0; i < 256; i++) exp_q.push_back(g ? 8'(i ^ (i >> 1)) : 8'(i));
        lastc = g ? 8'h80 : 8'hFF;
        sess_gray = g; sig_m = '0; have_prev = 0;
        for (int i = 0; i < 256; i++) seen[i] = 0;
        @(negedge clk); gray_mode = g; start = 1'b1;
        @(posedge clk); mon_on = 1;
        @(negedge clk); start = 1'b0;
        if (disturb) begin
            repeat (100) @(negedge clk);
            start = 1'b1; gray_mode = !g;      // R8 R10: must be ignored
            @(negedge clk); start = 1'b0;
        end
        wait (!mon_on);
        @(negedge clk);
        chk(done == 1'b1, "R2 R7 done after 256 vectors", done, 1);
        chk(signature == sig_m, "R9 final signature", signature, sig_m);
        for (int h = 0; h < 3; h++) begin
            gray_mode = !gray_mode;
            @(negedge clk);
            chk(done && op_a == rep_a(lastc) && op_b == rep_b(lastc), "R7 R10 hold",
                {op_a, op_b}, {rep_a(lastc), rep_b(lastc)});
            chk(signature == sig_m, "R7 signature hold", signature, sig_m);
        end
        if (g) begin
            uniq = 0;
            for (int i = 0; i < 256; i++) uniq += int'(seen[i]);
            chk(uniq == 256, "R4 distinct codes", uniq, 256);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(op_a == '0 && op_b == '0, "R1 reset operands", {op_a, op_b}, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        chk(signature == '0, "R1 reset signature", signature, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && op_a == '0, "R1 idle without start", {done, op_a}, 0);
        run_session(1'b0, 1'b0);
        run_session(1'b1, 1'b1);
        run_session(1'b0, 1'b1);
        run_session(1'b1, 1'b0);
        finish_run();
    end
endmodule